// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two timer/counters, each made of a high count byte and a low count byte. A clock prescaler divides the input clock into machine-cycle ticks. Each timer counts either those ticks or falling edges seen on its own count pin. An optional gate makes counting depend on the level of an external interrupt pin as well as on the timer's run bit. Overflow flags go to an interrupt controller, which clears a flag through a dedicated acknowledge input when it takes the interrupt.

Each timer has a 2-bit mode field that selects one of four counting structures:
- 13-bit count.
- 16-bit count.
- 8-bit count with automatic reload.
- Split operation, on timer 0 only. Timer 0 becomes two independent 8-bit counters, and its high byte takes over timer 1's run bit and overflow flag.

A one-cycle pulse on every timer 1 overflow is available as a baud-rate source.

The register port is plain control, not a stream. A write is taken in the cycle that `wr_en` is high and is never held off. Reads are combinational from `rd_addr`, so the port has no valid/ready handshake and no back-pressure.

Top module: `dual_tc_unit`

## Requirements
- R1: After reset, every register reads 0x00, both overflow flags are 0 and `t1_ovf_pulse` is 0.
- R2: The prescaler produces one tick every PRESCALE clocks (PRESCALE ≥ 2), with the first tick on the PRESCALE-th rising edge after reset. In timer operation, each tick advances an enabled count by one.
- R3: Mode 0 is a 13-bit count. The low 5 bits of the low byte carry into the high byte, and bits 7:5 of the low byte never change through counting. A step from all ones wraps the 13 bits to zero and sets the flag.
- R4: Mode 1 is a 16-bit count {high, low}. A step from 0xFFFF wraps to 0x0000 and sets the flag.
- R5: Mode 2 counts in the low byte only. A step from 0xFF loads the low byte from the high byte and sets the flag.
- R6: When the ext bit (bit 2 of the timer's mode nibble) is 1, the count pin is sampled on each tick. The timer steps once on each tick where the previous sample was 1 and the current pin level is 0.
- R7: When the gate bit (bit 3 of the nibble) is 1, the timer steps only while its gate pin is high. When it is 0, the run bit alone enables the timer.
- R8: Split operation:
  - When timer 0 is in mode 3, its low byte keeps timer 0's run, gate and ext controls and sets flag 0.
  - Its high byte counts ticks whenever run bit 1 is set, and its overflow sets flag 1.
  - While timer 0 is split, timer 1 ignores its run bit (gate and ext still apply), and its overflows do not set flag 1.
  - A timer 1 set to mode 3 holds its count.
- R9: `t1_ovf_pulse` is high for exactly the one cycle after each timer 1 overflow, whether or not timer 0 is split.
- R10: A write to a count byte wins over counting in the same cycle. A write to the control register sets both flags to the written bits, and this wins over overflow and acknowledge.
- R11: An acknowledge clears its flag. If an overflow occurs in the same cycle, the flag is set instead.
- R12: Register map:
  - 0 is the mode byte: timer 0 in bits 3:0 and timer 1 in bits 7:4. Within each nibble, bits 1:0 are the mode, bit 2 is ext and bit 3 is gate.
  - 1 is control: bit 0 run0, bit 1 run1, bit 2 flag0, bit 3 flag1, with upper bits reading 0.
  - 2 and 3 are timer 0 low and high.
  - 4 and 5 are timer 1 low and high.
  - 6 and 7 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| cnt_pin0 | input | 1 | External count pin, timer 0 |
| cnt_pin1 | input | 1 | External count pin, timer 1 |
| gate_pin0 | input | 1 | External gate level, timer 0 |
| gate_pin1 | input | 1 | External gate level, timer 1 |
| irq_ack0 | input | 1 | Flag 0 clear on interrupt acknowledge |
| irq_ack1 | input | 1 | Flag 1 clear on interrupt acknowledge |
| ovf_flag0 | output | 1 | Overflow flag 0 |
| ovf_flag1 | output | 1 | Overflow flag 1 |
| t1_ovf_pulse | output | 1 | One-cycle timer 1 overflow pulse |

## Verification
The bench builds the block with PRESCALE = 4 and keeps the default 5-bit low part of the 13-bit mode. With the shorter prescale, a 13-bit rollover, a reload and several split-mode overflows each fit within a few dozen clocks. Edge counting can also be driven at close to its highest rate, and single-cycle pin pulses fall between ticks, where they must be ignored. A behavioural model tracks every register, flag and the overflow pulse on every clock.

// File: rtl/dtc_pkg.sv
`timescale 1ns/1ps
package dtc_pkg;
  localparam int DW = 8;

  typedef enum logic [1:0] {
    TM_13     = 2'd0,
    TM_16     = 2'd1,
    TM_RELOAD = 2'd2,
    TM_SPLIT  = 2'd3
  } tmode_e;

  typedef struct packed {
    logic   gate;
    logic   ext;
    tmode_e mode;
  } tcfg_t;

  localparam logic [2:0] A_MODE = 3'd0;
  localparam logic [2:0] A_CTRL = 3'd1;
  localparam logic [2:0] A_T0L  = 3'd2;
  localparam logic [2:0] A_T0H  = 3'd3;
  localparam logic [2:0] A_T1L  = 3'd4;
  localparam logic [2:0] A_T1H  = 3'd5;
endpackage

// File: rtl/dtc_prescaler.sv
`timescale 1ns/1ps
module dtc_prescaler #(
  parameter int PRESCALE = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] pcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pcnt <= '0;
    else if (pcnt == LAST)  pcnt <= '0;
    else                    pcnt <= pcnt + 1'b1;
  end

  assign tick = (pcnt == LAST);

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n) tick |=> !tick) else $error("tick on adjacent cycles"); // R2
endmodule

// File: rtl/dtc_edge_sampler.sv
`timescale 1ns/1ps
module dtc_edge_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin,
  output logic fall
);
  logic samp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    samp <= 1'b0;
    else if (tick) samp <= pin;
  end

  assign fall = tick & samp & ~pin;

  AST_FALL_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n) fall |=> !samp) else $error("fall without low sample"); // R6
endmodule

// File: rtl/dtc_counter.sv
`timescale 1ns/1ps
module dtc_counter
  import dtc_pkg::*;
#(
  parameter int FRAC     = 5,
  parameter bit SPLIT_OK = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  tmode_e        mode,
  input  logic          inc,
  input  logic          inc_hi,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] lo,
  output logic [DW-1:0] hi,
  output logic          ovf_main,
  output logic          ovf_hi
);
  localparam int W13 = DW + FRAC + 1;
  localparam int W16 = 2 * DW + 1;
  localparam int W8  = DW + 1;

  logic [DW-1:0] lo_n, hi_n;
  logic [W13-1:0] sum13;
  logic [W16-1:0] sum16;
  logic [W8-1:0]  sum_lo, sum_hi;

  always_comb begin
    sum13  = {1'b0, hi, lo[FRAC-1:0]} + W13'(1);
    sum16  = {1'b0, hi, lo} + W16'(1);
    sum_lo = {1'b0, lo} + W8'(1);
    sum_hi = {1'b0, hi} + W8'(1);
  end

  always_comb begin
    lo_n     = lo;
    hi_n     = hi;
    ovf_main = 1'b0;
    ovf_hi   = 1'b0;
    case (mode)
      TM_13: begin
        if (inc) begin
          lo_n[FRAC-1:0] = sum13[FRAC-1:0];
          hi_n           = sum13[DW+FRAC-1:FRAC];
          ovf_main       = sum13[W13-1];
        end
      end
      TM_16: begin
        if (inc) begin
          lo_n     = sum16[DW-1:0];
          hi_n     = sum16[2*DW-1:DW];
          ovf_main = sum16[W16-1];
        end
      end
      TM_RELOAD: begin
        if (inc) begin
          if (sum_lo[W8-1]) begin
            lo_n     = hi;
            ovf_main = 1'b1;
          end else begin
            lo_n = sum_lo[DW-1:0];
          end
        end
      end
      TM_SPLIT: begin
        if (SPLIT_OK) begin
          if (inc) begin
            lo_n     = sum_lo[DW-1:0];
            ovf_main = sum_lo[W8-1];
          end
          if (inc_hi) begin
            hi_n   = sum_hi[DW-1:0];
            ovf_hi = sum_hi[W8-1];
          end
        end
      end
      default: ;
    endcase
    if (wr_lo) lo_n = wr_data;
    if (wr_hi) hi_n = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo <= '0;
      hi <= '0;
    end else begin
      lo <= lo_n;
      hi <= hi_n;
    end
  end

  AST_RELOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n) (mode == TM_RELOAD && inc && lo == '1 && !wr_lo) |=> (lo == $past(hi))) else $error("reload mismatch"); // R5
  AST_TOP_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n) (mode == TM_13 && !wr_lo) |=> (lo[DW-1:FRAC] == $past(lo[DW-1:FRAC]))) else $error("13-bit top bits moved"); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (!inc && !inc_hi && !wr_lo && !wr_hi) |=> ($stable(lo) && $stable(hi))) else $error("count moved while idle"); // R7
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n) wr_lo |=> (lo == $past(wr_data))) else $error("write lost"); // R10
endmodule

// File: rtl/dtc_regs.sv
`timescale 1ns/1ps
module dtc_regs
  import dtc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [2:0]    rd_addr,
  input  logic [DW-1:0] t0_lo,
  input  logic [DW-1:0] t0_hi,
  input  logic [DW-1:0] t1_lo,
  input  logic [DW-1:0] t1_hi,
  input  logic          set0,
  input  logic          set1,
  input  logic          ack0,
  input  logic          ack1,
  output tcfg_t         cfg0,
  output tcfg_t         cfg1,
  output logic          run0,
  output logic          run1,
  output logic          flag0,
  output logic          flag1,
  output logic [DW-1:0] rd_data
);
  logic ctrl_wr;
  assign ctrl_wr = wr_en && (wr_addr == A_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg0  <= '0;
      cfg1  <= '0;
      run0  <= 1'b0;
      run1  <= 1'b0;
      flag0 <= 1'b0;
      flag1 <= 1'b0;
    end else begin
      if (wr_en && wr_addr == A_MODE) {cfg1, cfg0} <= wr_data;
      if (ctrl_wr) {run1, run0} <= wr_data[1:0];

      if (ctrl_wr)   flag0 <= wr_data[2];
      else if (set0) flag0 <= 1'b1;
      else if (ack0) flag0 <= 1'b0;

      if (ctrl_wr)   flag1 <= wr_data[3];
      else if (set1) flag1 <= 1'b1;
      else if (ack1) flag1 <= 1'b0;
    end
  end

  always_comb begin
    case (rd_addr)
      A_MODE:  rd_data = {cfg1, cfg0};
      A_CTRL:  rd_data = {{(DW-4){1'b0}}, flag1, flag0, run1, run0};
      A_T0L:   rd_data = t0_lo;
      A_T0H:   rd_data = t0_hi;
      A_T1L:   rd_data = t1_lo;
      A_T1H:   rd_data = t1_hi;
      default: rd_data = '0;
    endcase
  end

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (ack0 && !set0 && !ctrl_wr) |=> !flag0) else $error("ack did not clear"); // R11
  AST_FLAG_ON_OVF: assert property (@(posedge clk) disable iff (!rst_n) (set1 && !ctrl_wr) |=> flag1) else $error("overflow lost to ack"); // R11
endmodule

// File: rtl/dual_tc_unit.sv
`timescale 1ns/1ps
module dual_tc_unit
  import dtc_pkg::*;
#(
  parameter int PRESCALE = 12,
  parameter int FRAC     = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [2:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          cnt_pin0,
  input  logic          cnt_pin1,
  input  logic          gate_pin0,
  input  logic          gate_pin1,
  input  logic          irq_ack0,
  input  logic          irq_ack1,
  output logic          ovf_flag0,
  output logic          ovf_flag1,
  output logic          t1_ovf_pulse
);
  localparam int NT = 2;

  logic          tick;
  logic [NT-1:0] pins, fall;
  tcfg_t         cfg0, cfg1;
  logic          run0, run1;
  logic          split0, inc0, inc1, inc_hi0;
  logic          ovf_m0, ovf_h0, ovf_m1, ovf_h1;
  logic          set1;
  logic [DW-1:0] t0_lo, t0_hi, t1_lo, t1_hi;

  dtc_prescaler #(.PRESCALE(PRESCALE)) u_pre (.clk(clk), .rst_n(rst_n), .tick(tick));

  assign pins = {cnt_pin1, cnt_pin0};
  for (genvar i = 0; i < NT; i++) begin : g_smp
    dtc_edge_sampler u_smp (.clk(clk), .rst_n(rst_n), .tick(tick), .pin(pins[i]), .fall(fall[i]));
  end

  assign split0  = (cfg0.mode == TM_SPLIT);
  assign inc0    = run0 && (!cfg0.gate || gate_pin0) && (cfg0.ext ? fall[0] : tick);
  assign inc1    = (split0 || run1) && (!cfg1.gate || gate_pin1) && (cfg1.ext ? fall[1] : tick);
  assign inc_hi0 = split0 && run1 && tick;
  assign set1    = split0 ? ovf_h0 : ovf_m1;

  dtc_counter #(.FRAC(FRAC), .SPLIT_OK(1'b1)) u_t0 (
    .clk(clk), .rst_n(rst_n), .mode(cfg0.mode), .inc(inc0), .inc_hi(inc_hi0),
    .wr_lo(wr_en && wr_addr == A_T0L), .wr_hi(wr_en && wr_addr == A_T0H), .wr_data(wr_data),
    .lo(t0_lo), .hi(t0_hi), .ovf_main(ovf_m0), .ovf_hi(ovf_h0)
  );

  dtc_counter #(.FRAC(FRAC), .SPLIT_OK(1'b0)) u_t1 (
    .clk(clk), .rst_n(rst_n), .mode(cfg1.mode), .inc(inc1), .inc_hi(1'b0),
    .wr_lo(wr_en && wr_addr == A_T1L), .wr_hi(wr_en && wr_addr == A_T1H), .wr_data(wr_data),
    .lo(t1_lo), .hi(t1_hi), .ovf_main(ovf_m1), .ovf_hi(ovf_h1)
  );

  dtc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .t0_lo(t0_lo), .t0_hi(t0_hi), .t1_lo(t1_lo), .t1_hi(t1_hi),
    .set0(ovf_m0), .set1(set1), .ack0(irq_ack0), .ack1(irq_ack1),
    .cfg0(cfg0), .cfg1(cfg1), .run0(run0), .run1(run1),
    .flag0(ovf_flag0), .flag1(ovf_flag1), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) t1_ovf_pulse <= 1'b0;
    else        t1_ovf_pulse <= ovf_m1 | ovf_h1;
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) t1_ovf_pulse |=> !t1_ovf_pulse) else $error("pulse too long"); // R9
  AST_SPLIT_FLAG1: assert property (@(posedge clk) disable iff (!rst_n) (split0 && !ovf_h0 && !ovf_flag1 && !(wr_en && wr_addr == A_CTRL)) |=> !ovf_flag1) else $error("flag1 set by timer1 in split"); // R8
endmodule

// File: tb/tb_dual_tc_unit.sv
`timescale 1ns/1ps
module tb_dual_tc_unit;
  localparam int P = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic cnt_pin0 = 1'b0, cnt_pin1 = 1'b0, gate_pin0 = 1'b0, gate_pin1 = 1'b0;
  logic irq_ack0 = 1'b0, irq_ack1 = 1'b0;
  logic ovf_flag0, ovf_flag1, t1_ovf_pulse;

  int checks = 0, failures = 0;
  bit done = 0;
  string cur_req = "R1";
  logic [7:0] snap [8];

  int m_pc, m_s0, m_s1, m_mode, m_run0, m_run1, m_f0, m_f1, m_pulse;
  int m_lo [2];
  int m_hi [2];

  always #4 clk = ~clk;

  dual_tc_unit #(.PRESCALE(P)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cnt_pin0(cnt_pin0), .cnt_pin1(cnt_pin1),
    .gate_pin0(gate_pin0), .gate_pin1(gate_pin1), .irq_ack0(irq_ack0), .irq_ack1(irq_ack1),
    .ovf_flag0(ovf_flag0), .ovf_flag1(ovf_flag1), .t1_ovf_pulse(t1_ovf_pulse)
  );

  task automatic step_t(input int md, input bit inc, input bit inchi, input bit splitok,
                        inout int lo, inout int hi, output bit ov, output bit ovh);
    int v;
    ov = 0; ovh = 0;
    case (md)
      0: if (inc) begin
        v = hi * 32 + (lo % 32); ov = (v == 8191); v = (v + 1) % 8192;
        lo = (lo / 32) * 32 + (v % 32); hi = v / 32;
      end
      1: if (inc) begin
        v = hi * 256 + lo; ov = (v == 65535); v = (v + 1) % 65536;
        lo = v % 256; hi = v / 256;
      end
      2: if (inc) begin
        if (lo == 255) begin lo = hi; ov = 1; end else lo = lo + 1;
      end
      default: if (splitok) begin
        if (inc)   begin ov  = (lo == 255); lo = (lo + 1) % 256; end
        if (inchi) begin ovh = (hi == 255); hi = (hi + 1) % 256; end
      end
    endcase
  endtask

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_pc = 0; m_s0 = 0; m_s1 = 0; m_mode = 0; m_run0 = 0; m_run1 = 0;
      m_f0 = 0; m_f1 = 0; m_pulse = 0;
      m_lo[0] = 0; m_lo[1] = 0; m_hi[0] = 0; m_hi[1] = 0;
    end else begin
      bit tk, f0, f1, split, inc0, inc1, inchi, ov0, ovh0, ov1, ovh1, wrc;
      int n0, e0, g0, n1, e1, g1, nf0, nf1;
      tk = (m_pc == P - 1);
      f0 = tk && m_s0 == 1 && cnt_pin0 == 0;
      f1 = tk && m_s1 == 1 && cnt_pin1 == 0;
      if (tk) begin m_s0 = cnt_pin0; m_s1 = cnt_pin1; end
      m_pc = tk ? 0 : m_pc + 1;
      n0 = m_mode % 4; e0 = (m_mode >> 2) & 1; g0 = (m_mode >> 3) & 1;
      n1 = (m_mode >> 4) & 3; e1 = (m_mode >> 6) & 1; g1 = (m_mode >> 7) & 1;
      split = (n0 == 3);
      inc0  = m_run0 != 0 && (g0 == 0 || gate_pin0) && (e0 != 0 ? f0 : tk);
      inc1  = (split || m_run1 != 0) && (g1 == 0 || gate_pin1) && (e1 != 0 ? f1 : tk);
      inchi = split && m_run1 != 0 && tk;
      step_t(n0, inc0, inchi, 1, m_lo[0], m_hi[0], ov0, ovh0);
      step_t(n1, inc1, 0, 0, m_lo[1], m_hi[1], ov1, ovh1);
      wrc = wr_en && wr_addr == 3'd1;
      nf0 = wrc ? int'(wr_data[2]) : ov0 ? 1 : irq_ack0 ? 0 : m_f0;
      nf1 = wrc ? int'(wr_data[3]) : (split ? ovh0 : ov1) ? 1 : irq_ack1 ? 0 : m_f1;
      m_pulse = ov1;
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_mode = wr_data;
          3'd1: begin m_run0 = wr_data[0]; m_run1 = wr_data[1]; end
          3'd2: m_lo[0] = wr_data;
          3'd3: m_hi[0] = wr_data;
          3'd4: m_lo[1] = wr_data;
          3'd5: m_hi[1] = wr_data;
          default: ;
        endcase
      end
      m_f0 = nf0; m_f1 = nf1;
    end
  end

  function automatic int exp_reg(input int a);
    case (a)
      0: return m_mode;
      1: return m_f1 * 8 + m_f0 * 4 + m_run1 * 2 + m_run0;
      2: return m_lo[0];
      3: return m_hi[0];
      4: return m_lo[1];
      5: return m_hi[1];
      default: return 0;
    endcase
  endfunction

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit bad;
      #0.5;
      for (int a = 0; a < 8; a++) begin
        rd_addr = a[2:0];
        #0.3;
        snap[a] = rd_data;
      end
      checks++;
      bad = 0;
      for (int a = 0; a < 8 && !bad; a++) begin
        if (int'(snap[a]) != exp_reg(a)) begin
          bad = 1;
          $display("FAIL %s: reg %0d actual %h expected %h at %0t", cur_req, a, snap[a], exp_reg(a), $time);
        end
      end
      if (!bad && (int'(ovf_flag0) != m_f0 || int'(ovf_flag1) != m_f1 || int'(t1_ovf_pulse) != m_pulse)) begin
        bad = 1;
        $display("FAIL %s: flags/pulse actual %b%b%b expected %0d%0d%0d at %0t", cur_req,
                 ovf_flag0, ovf_flag1, t1_ovf_pulse, m_f0, m_f1, m_pulse, $time);
      end
      if (bad) failures++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic settle();
    @(negedge clk); #3.5;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wait_flag(input int which, input string req);
    bit seen = 0;
    for (int i = 0; i < 200 && !seen; i++) begin
      settle();
      seen = (which == 0) ? ovf_flag0 : ovf_flag1;
    end
    chk(req, seen, 1);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    failures++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int pulses;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state, R12 map reads
    cur_req = "R1";
    settle();
    for (int a = 0; a < 8; a++) chk("R1", snap[a], 0);
    chk("R1", {ovf_flag0, ovf_flag1, t1_ovf_pulse}, 0);

    // R4 16-bit rollover, R2 tick rate
    cur_req = "R4";
    wr(3'd0, 8'h01); wr(3'd2, 8'hFE); wr(3'd3, 8'hFF); wr(3'd1, 8'h01);
    wait_flag(0, "R4");
    chk("R4", {snap[3], snap[2]}, 16'h0000);
    cur_req = "R2";
    repeat (4 * P) @(negedge clk);
    #3.5;
    chk("R2", snap[2], 8'h04);

    // R3 13-bit
    cur_req = "R3";
    wr(3'd1, 8'h00); wr(3'd0, 8'h00); wr(3'd2, 8'hBE); wr(3'd3, 8'hFF); wr(3'd1, 8'h01);
    wait_flag(0, "R3");
    chk("R3", snap[2], 8'hA0);
    chk("R3", snap[3], 8'h00);

    // R5 reload
    cur_req = "R5";
    wr(3'd1, 8'h00); wr(3'd0, 8'h02); wr(3'd3, 8'hF0); wr(3'd2, 8'hFE); wr(3'd1, 8'h01);
    wait_flag(0, "R5");
    chk("R5", snap[2], 8'hF0);
    repeat (3 * P) @(negedge clk);
    #3.5;
    chk("R5", snap[2], 8'hF3);

    // R11 acknowledge
    cur_req = "R11";
    @(negedge clk); irq_ack0 = 1;
    @(negedge clk); irq_ack0 = 0; #3.5;
    chk("R11", ovf_flag0, 0);
    wr(3'd1, 8'h00);

    // R6 external edges on timer 1
    cur_req = "R6";
    wr(3'd0, 8'h50); wr(3'd4, 8'h00); wr(3'd5, 8'h00); wr(3'd1, 8'h02);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); cnt_pin1 = 1;
      repeat (3 * P) @(negedge clk);
      cnt_pin1 = 0;
      repeat (3 * P) @(negedge clk);
    end
    settle();
    chk("R6", snap[4], 5);
    for (int k = 0; k < 6; k++) begin   // single-cycle highs mostly missed between ticks
      @(negedge clk); cnt_pin1 = ~cnt_pin1;
    end
    cnt_pin1 = 0;

    // R7 gate
    cur_req = "R7";
    wr(3'd1, 8'h00); wr(3'd0, 8'h90); wr(3'd4, 8'h00); wr(3'd5, 8'h00); wr(3'd1, 8'h02);
    repeat (5 * P) @(negedge clk);
    #3.5;
    chk("R7", snap[4], 0);
    @(negedge clk); gate_pin1 = 1;
    repeat (5 * P) @(negedge clk);
    #3.5;
    chk("R7", snap[4], 5);

    // R8 split, R9 pulse
    cur_req = "R8";
    wr(3'd1, 8'h00); wr(3'd0, 8'h23);
    wr(3'd2, 8'hF0); wr(3'd3, 8'hFE); wr(3'd4, 8'hFD); wr(3'd5, 8'hFD);
    pulses = 0;
    for (int k = 0; k < 10 * P; k++) begin
      settle();
      if (t1_ovf_pulse) pulses++;
    end
    chk("R9", pulses >= 2, 1);
    chk("R8", ovf_flag1, 0);
    chk("R8", snap[3], 8'hFE);
    wr(3'd1, 8'h02);
    wait_flag(1, "R8");
    chk("R8", snap[3], 8'h00);
    chk("R8", snap[2], 8'hF0);
    wr(3'd1, 8'h00); wr(3'd0, 8'h30); wr(3'd4, 8'h55); wr(3'd1, 8'h02);
    repeat (4 * P) @(negedge clk);
    #3.5;
    chk("R8", snap[4], 8'h55);

    // R10 write priority, R12 map
    cur_req = "R10";
    wr(3'd1, 8'h00); wr(3'd0, 8'h01); wr(3'd1, 8'h01);
    @(negedge clk); wr_en = 1; wr_addr = 3'd2; wr_data = 8'h10;
    repeat (2 * P) @(negedge clk);
    wr_en = 0; #3.5;
    chk("R10", snap[2], 8'h10);
    wr(3'd1, 8'h0C);
    settle();
    chk("R10", {ovf_flag1, ovf_flag0}, 2'b11);
    chk("R12", snap[1], 8'h0C);
    cur_req = "R11";
    @(negedge clk); irq_ack0 = 1; irq_ack1 = 1;
    @(negedge clk); irq_ack0 = 0; irq_ack1 = 0; #3.5;
    chk("R11", {ovf_flag1, ovf_flag0}, 2'b00);
    cur_req = "R12";
    wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
    settle();
    chk("R12", snap[6], 0);
    chk("R12", snap[7], 0);
    chk("R12", snap[0], 8'h01);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule